// File: doc/BRIEF.md
# Per-Lane Variable Vector Shifter

This block shifts every element of a 64-bit packed vector by its own amount. The amount comes from the matching element of a second packed vector. Elements are 8, 16 or 32 bits wide and either signed or unsigned. The low byte of each element of the count vector is a two's-complement number, so each lane can shift left or right independently of its neighbours. Two option bits modify the basic shift and may be used together. The rounding option makes right shifts round to nearest. The saturating option makes left shifts clamp instead of wrapping. With neither option set, the shift is a plain shift.

A request is presented with `in_valid` and its result appears one clock later, registered, together with `out_valid`. When any lane saturates, a sticky overflow flag is raised. The flag stays set until the surrounding logic pulses `sat_clr`. Carries and shifted bits never cross lane boundaries.

Top module: `vec_var_shift`

## Requirements
- R1: A request accepted with `in_valid` high at a rising edge appears on `result` after that edge, with `out_valid` high for exactly that cycle. While `in_valid` is low, `out_valid` is low and `result` holds its last value.
- R2: A lane whose count byte is zero passes its element through unchanged in every mode and never raises the flag.
- R3: `esize` selects the lane width: 00 gives 8-bit lanes, 01 gives 16-bit lanes, and 10 or 11 give 32-bit lanes. Each lane's count is bits [7:0] of its element in `cnt_v`, read as two's complement. Higher bits of the element are ignored. A negative count shifts right by its magnitude and a positive count shifts left.
- R4: A right shift fills vacated bits with zeros for unsigned lanes and with copies of the sign bit for signed lanes. A magnitude of at least the lane width gives 0, or all ones for a negative signed source.
- R5: A plain left shift drops the bits that leave the lane and fills with zeros. A count of at least the lane width gives 0.
- R6: With `rnd_en`, a right shift by n adds bit n-1 of the source when n does not exceed the lane width. When n exceeds the width, it adds 1 for a negative signed source and 0 otherwise. The sum is truncated to the lane. Rounding has no effect on left shifts.
- R7: For an unsigned saturating left shift, a result that does not fit the lane becomes all ones and raises the flag. A nonzero source shifted by at least the width always overflows. A zero source gives 0 and does not raise the flag.
- R8: For a signed saturating left shift, a result outside the signed range becomes the largest positive value for a non-negative source, or the most negative value for a negative source, and raises the flag.
- R9: `sat_flag` is sticky. It drops one cycle after `sat_clr` is asserted, unless a lane saturates in that same cycle, in which case it stays set.
- R10: After reset, `result`, `out_valid` and `sat_flag` are all 0. Only saturating left shifts that overflow raise the flag. Right shifts never do, even when `sat_en` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | 64 | Packed elements to shift |
| cnt_v | input | 64 | Packed elements whose low byte is the signed shift count |
| esize | input | 2 | Lane width select |
| is_signed | input | 1 | Treat elements as two's complement |
| rnd_en | input | 1 | Round right shifts |
| sat_en | input | 1 | Saturate left shifts |
| sat_clr | input | 1 | Clear the sticky flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Packed shifted elements |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
On every cycle, the assertions check the handshake timing, the holding of the result, the pass-through of zero counts, and the set, hold and clear rules of the sticky flag. The per-lane arithmetic cannot be checked that way. This covers the sign fill, the rounding increment beyond the lane width, the clamping direction and the over-width counts. The bench's scenarios show these by comparing each lane against hand-worked vectors and an arithmetic reference model, across all widths and option combinations.

// File: rtl/vec_var_shift.sv
module vec_var_shift #(
  parameter int VEC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] cnt_v,
  input  logic [1:0]       esize,
  input  logic             is_signed,
  input  logic             rnd_en,
  input  logic             sat_en,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             sat_flag
);

  localparam int NSZ = 3;

  logic [NSZ-1:0][VEC_W-1:0] res_by;
  logic [NSZ-1:0]            hit_by;
  logic [VEC_W-1:0]          res_sel;
  logic                      hit_any;

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int W = 8 << s;
    localparam int L = VEC_W / W;
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    logic [L-1:0] hits;

    for (genvar i = 0; i < L; i++) begin : g_ln
      logic [W-1:0] x, r, sh;
      logic [7:0]   c;
      logic [63:0]  ext, full;
      logic         neg, ovf, h;
      int           n;

      assign x   = src_a[W*i +: W];
      assign c   = cnt_v[W*i +: 8];
      assign neg = is_signed & x[W-1];

      always_comb begin
        ext  = is_signed ? 64'($signed(x)) : {{(64-W){1'b0}}, x};
        r    = x;
        h    = 1'b0;
        ovf  = 1'b0;
        n    = 0;
        sh   = '0;
        full = '0;
        if (c[7]) begin
          n  = 256 - int'(c);
          sh = (n >= W) ? {W{neg}} : W'($signed(ext) >>> n);
          if (rnd_en)
            sh = sh + W'((n <= W) ? ext[6'(n-1)] : neg);
          r = sh;
        end else if (c != 8'd0) begin
          n    = int'(c);
          full = (n >= W) ? 64'd0 : (ext << n);
          if (n >= W)
            ovf = (x != '0);
          else if (is_signed)
            ovf = (full != 64'($signed(full[W-1:0])));
          else
            ovf = (full != {{(64-W){1'b0}}, full[W-1:0]});
          r = full[W-1:0];
          if (sat_en && ovf) begin
            h = 1'b1;
            r = is_signed ? (neg ? MINV : MAXV) : '1;
          end
        end
      end

      assign res_by[s][W*i +: W] = r;
      assign hits[i] = h;
    end

    assign hit_by[s] = |hits;
  end

  always_comb begin
    case (esize)
      2'b00:   begin res_sel = res_by[0]; hit_any = hit_by[0]; end
      2'b01:   begin res_sel = res_by[1]; hit_any = hit_by[1]; end
      default: begin res_sel = res_by[2]; hit_any = hit_by[2]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_sel;
      sat_flag <= (sat_flag & ~sat_clr) | (in_valid & hit_any);
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));
  a_r2_zero_count_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_v == '0) |=> result == $past(src_a));
  a_r2_zero_count_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_v == '0 && !sat_flag) |=> !sat_flag);
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);
  a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !(in_valid && hit_any)) |=> !sat_flag);
  a_r10_flag_needs_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_flag && !(in_valid && sat_en)) |=> !sat_flag);

endmodule

// File: tb/vec_var_shift_test.sv
module vec_var_shift_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src_a = '0, cnt_v = '0;
  logic [1:0]  esize = '0;
  logic        is_signed = 1'b0, rnd_en = 1'b0, sat_en = 1'b0, sat_clr = 1'b0;
  logic        out_valid, sat_flag;
  logic [63:0] result;

  always #5 clk = ~clk;

  vec_var_shift uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .cnt_v(cnt_v),
    .esize(esize), .is_signed(is_signed), .rnd_en(rnd_en), .sat_en(sat_en),
    .sat_clr(sat_clr), .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
  );

  typedef struct {
    logic [63:0] res;
    logic        flag;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          n_chk = 0, n_fail = 0;
  logic        mflag = 1'b0;
  logic [63:0] last_res = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint ref_lane(input longint xu, input int cb, input int w,
                                      input bit sgn, input bit rnd, input bit sat,
                                      output bit hit);
    longint v, res, umax, smax, smin;
    int c, n;
    bit ovf;
    umax = (longint'(1) << w) - 1;
    smax = (longint'(1) << (w - 1)) - 1;
    smin = -(longint'(1) << (w - 1));
    v = (sgn && xu[w-1]) ? xu - (longint'(1) << w) : xu;
    c = (cb > 127) ? cb - 256 : cb;
    hit = 1'b0;
    ovf = 1'b0;
    if (c == 0) res = v;
    else if (c < 0) begin
      n = (-c > 40) ? 40 : -c;
      res = rnd ? ((v + (longint'(1) << (n - 1))) >>> n) : (v >>> n);
    end else begin
      n = c;
      if (n >= w) begin ovf = (v != 0); res = 0; end
      else begin
        res = v << n;
        ovf = sgn ? (res > smax || res < smin) : (res > umax);
      end
      if (sat && ovf) begin
        hit = 1'b1;
        res = sgn ? ((v < 0) ? smin : smax) : umax;
      end
    end
    return res & umax;
  endfunction

  task automatic push_drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] es,
                            input bit sg, input bit rd, input bit st, input bit clr,
                            input logic [63:0] er, input bit eh, input string tag);
    item_t it;
    @(negedge clk);
    src_a = a; cnt_v = b; esize = es; is_signed = sg; rnd_en = rd; sat_en = st;
    sat_clr = clr; in_valid = 1'b1;
    mflag = (mflag & ~clr) | eh;
    it.res = er; it.flag = mflag; it.tag = tag;
    sb.push_back(it);
    last_res = er;
  endtask

  task automatic send_dir(input logic [63:0] a, input logic [63:0] b, input logic [1:0] es,
                          input bit sg, input bit rd, input bit st, input bit clr,
                          input logic [63:0] er, input bit eh, input string tag);
    push_drive(a, b, es, sg, rd, st, clr, er, eh, tag);
  endtask

  task automatic send_rnd(input logic [63:0] a, input logic [63:0] b, input logic [1:0] es,
                          input bit sg, input bit rd, input bit st, input bit clr);
    int w;
    logic [63:0] er;
    bit eh, lh;
    longint lr;
    w = (es == 2'b00) ? 8 : (es == 2'b01) ? 16 : 32;
    er = '0;
    eh = 1'b0;
    for (int i = 0; i < 64 / w; i++) begin
      lr = ref_lane(longint'((a >> (w * i)) & ((64'd1 << w) - 1)),
                    int'((b >> (w * i)) & 64'hFF), w, sg, rd, st, lh);
      er = er | ((64'(lr) & ((64'd1 << w) - 1)) << (w * i));
      eh = eh | lh;
    end
    push_drive(a, b, es, sg, rd, st, clr, er, eh, "R3 R4 R5 R6 R7 R8 random lanes");
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R1 unexpected out_valid actual=1 expected=0");
      end else begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " result"}, result, it.res);
        check({it.tag, " flag"}, 64'(sat_flag), 64'(it.flag));
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset result", result, 64'd0);
    check("R10 reset valid", 64'(out_valid), 64'd0);
    check("R10 reset flag", 64'(sat_flag), 64'd0);

    send_dir(64'h8040201008040201, 64'h0101010101010101, 2'b00, 0, 0, 0, 0, 64'h0080402010080402, 0, "R5 left by one");
    send_dir(64'h8040201008040201, 64'hFFFFFFFFFFFFFFFF, 2'b00, 1, 0, 0, 0, 64'hC020100804020100, 0, "R4 signed right one");
    send_dir(64'h8040201008040201, 64'hFFFFFFFFFFFFFFFF, 2'b00, 0, 0, 0, 0, 64'h4020100804020100, 0, "R4 unsigned right one");
    send_dir(64'h80007FFFFFFF1234, 64'hABF000F055F000F0, 2'b01, 1, 0, 0, 0, 64'hFFFF0000FFFF0000, 0, "R3 R4 width-wide signed right");
    send_dir(64'h0302FF0100000000, 64'hFFFFFFFFFFFFFFFF, 2'b00, 0, 1, 0, 0, 64'h0201800100000000, 0, "R6 rounding right one");
    send_dir(64'h807FFF0100000000, 64'hF7F7F7F7F7F7F7F7, 2'b00, 1, 1, 0, 0, 64'h0000000000000000, 0, "R6 rounding beyond width");
    send_dir(64'h807FFF0100000000, 64'hF7F7F7F7F7F7F7F7, 2'b00, 1, 0, 0, 0, 64'hFF00FF0000000000, 0, "R4 plain beyond width");
    send_dir(64'h807F000000000000, 64'hF8F8F8F8F8F8F8F8, 2'b00, 0, 1, 0, 0, 64'h0100000000000000, 0, "R6 rounding at width");
    send_dir(64'h0000000380000001, 64'h0000000100000001, 2'b10, 0, 1, 0, 0, 64'h0000000600000002, 0, "R6 rounding left unaffected");
    send_dir(64'h1234123412341234, 64'h0010007F00110003, 2'b01, 0, 0, 0, 0, 64'h00000000000091A0, 0, "R5 left at and past width");
    send_dir(64'hFFFFFFFFFFFFFFFF, 64'hF8F8F8F8F8F8F8F8, 2'b00, 0, 0, 1, 0, 64'h0000000000000000, 0, "R10 sat right no flag");
    send_dir(64'h100000000FFFFFFF, 64'h0000000400000004, 2'b10, 0, 0, 1, 0, 64'hFFFFFFFFFFFFFFF0, 1, "R7 unsigned sat left");
    send_dir(64'h0, 64'h0, 2'b00, 0, 0, 0, 1, 64'h0, 0, "R9 clear");
    send_dir(64'h100000000FFFFFFF, 64'h0000000400000004, 2'b11, 0, 0, 1, 0, 64'hFFFFFFFFFFFFFFF0, 1, "R3 size code 11");
    send_dir(64'h0101010101010101, 64'h0101010101010101, 2'b00, 0, 0, 0, 0, 64'h0202020202020202, 0, "R9 sticky hold");
    send_dir(64'h0, 64'h0028002800280028, 2'b01, 0, 0, 1, 1, 64'h0, 0, "R7 zero source");
    send_dir(64'h0001000000000000, 64'h0010006400000000, 2'b01, 0, 0, 1, 0, 64'hFFFF000000000000, 1, "R7 over-width nonzero");
    send_dir(64'h40C0A001FF008105, 64'h0101010707640801, 2'b00, 1, 0, 1, 1, 64'h7F80807F8000800A, 1, "R8 R9 signed clamp, set wins");
    send_dir(64'h80017FFF1234FFFF, 64'hFF0001000000AB00, 2'b01, 1, 1, 1, 1, 64'h80017FFF1234FFFF, 0, "R2 zero count with clear");
    send_dir(64'h80017FFF1234FFFF, 64'hFF0001000000AB00, 2'b01, 1, 1, 1, 0, 64'h80017FFF1234FFFF, 0, "R2 zero count");

    for (int k = 0; k < 400; k++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (k % 3 == 0) b = b & 64'h0F0F0F0F0F0F0F0F;
      send_rnd(a, b, 2'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
               ($urandom % 8) == 0);
    end

    @(negedge clk);
    in_valid = 1'b0;
    sat_clr = 1'b0;
    src_a = '1;
    cnt_v = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1 idle valid low", 64'(out_valid), 64'd0);
    check("R1 idle result held", result, last_res);
    check("R1 queue drained", 64'(sb.size()), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule